// File: doc/BRIEF.md
# Serial Converter Command Interface

This block is the host-facing control port of a measurement converter. A host drives a four-wire synchronous serial link (active-low select, serial clock, data in, data out); the block oversamples those wires on its own system clock, decodes each 8-bit command byte, and then either shifts 24-bit words into the offset, gain or configuration register, shifts them back out, or shifts out the read-only conversion result. One select code moves all three set-up registers in a single 72-bit burst.

The converter core sees the set-up registers as parallel outputs. It receives a one-cycle start pulse for a single conversion and a power-save state with a mode flag. It hands back a 20-bit result, two status flags and a completion strobe. Completion raises a done flag inside the configuration word, so the host can poll for it. Reading the result word clears that flag.

Command byte layout: bit 7 marks a valid command, bit 6 requests a single conversion, bits 5:3 select the register, bit 2 is 1 for read and 0 for write, bit 1 is unused, and bit 0 is 1 for power save and 0 for run. Select codes: 000 offset, 001 gain, 010 configuration, 011 conversion data, 100 all three set-up registers.

Top module: `cvcmd_port`

## Requirements
- R1: After reset, the offset, gain and configuration outputs are zero. The serial output is 0, power save is off and no start pulse is issued.
- R2: A byte whose bit 7 is 0 is ignored: no register or state changes, and the next 8 bits in the same select frame are decoded as a new command.
- R3: A write command (bit 2 = 0) with select 000, 001 or 010 loads the following 24 bits, MSB first and sampled on rising serial clock edges, into the chosen register.
- R4: A read command (bit 2 = 1) presents the chosen 24-bit word MSB first on the serial output, which changes only on falling serial clock edges. The first bit is valid before the first rising edge after the command byte.
- R5: Select 100 transfers 72 bits in order offset, gain, configuration, for both write and read.
- R6: A write with select 011 consumes 24 bits and changes no register. The conversion word alters only on a conversion completion.
- R7: A valid byte with bit 6 = 0 and select 101, 110 or 111 has no effect at all: the power-save state is kept and no data phase follows.
- R8: The byte 0xC0 issues exactly one single-cycle start pulse and sets run state. A byte with bit 6 = 1 and any bit other than bit 7 set is ignored.
- R9: A completion strobe stores {result[19:0], 2'b00, flags[1:0]} as the conversion word and sets configuration bit 3 (done flag) to 1.
- R10: Reading the conversion word clears the done flag, and a completion in the same cycle wins. Host writes never change configuration bit 3.
- R11: Every accepted command (register access or 0xC0) loads bit 0 into the power-save output. The standby output is high when power save is on and configuration bit 4 is 0.
- R12: Raising the select line aborts any partial byte or word without a register update. The next frame starts with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| conv_res_i | input | 20 | Conversion result from core |
| conv_flags_i | input | 2 | Status flags accompanying the result |
| conv_done_i | input | 1 | One-cycle conversion completion strobe |
| conv_start_o | output | 1 | One-cycle single-conversion start |
| ofs_o | output | 24 | Offset register |
| gain_o | output | 24 | Gain register |
| cfg_o | output | 24 | Configuration register with done flag at bit 3 |
| pwr_save_o | output | 1 | Power-save state |
| pwr_standby_o | output | 1 | Power save active in standby mode |

## Verification
Register transport is tried with random words to random single-register selects, each read back serially and compared with the parallel output; this separates shift-order and alignment faults from decode faults. Directed frames cover the 72-bit burst in both directions, which exposes wrong word order. An invalid byte placed before a real command shows whether framing recovers inside one select frame. Reserved codes, a write to the read-only word, malformed conversion bytes and a select frame cut mid-word each have to leave every output untouched. The done flag is set by a completion, observed through a configuration read, and cleared by a result read.

// File: rtl/cvcmd_pkg.sv
package cvcmd_pkg;

  // command byte field positions (bit positions are part of the protocol)
  localparam int CB_VALID  = 7;
  localparam int CB_SINGLE = 6;
  localparam int CB_SEL_HI = 5;
  localparam int CB_SEL_LO = 3;
  localparam int CB_READ   = 2;
  localparam int CB_PS     = 0;
  localparam int CMD_W     = 8;

  localparam logic [2:0] SEL_OFS  = 3'b000;
  localparam logic [2:0] SEL_GAIN = 3'b001;
  localparam logic [2:0] SEL_CFG  = 3'b010;
  localparam logic [2:0] SEL_DATA = 3'b011;
  localparam logic [2:0] SEL_ALL  = 3'b100;

  localparam logic [CMD_W-1:0] CMD_CONVERT = 8'hC0;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } sif_state_e;

  typedef struct packed {
    logic       start;     // single-conversion request
    logic       access;    // register transfer follows
    logic       rd;        // read direction
    logic       multi;     // all set-up registers
    logic       ro;        // conversion word selected
    logic       reserved;  // reserved select code
    logic [1:0] idx;       // register index
    logic       ps;        // power-save request
  } cmd_dec_t;

endpackage

// File: rtl/cvcmd_sync.sv
module cvcmd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic rst_n_int,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);

  logic [1:0] rst_q;
  logic [1:0] cs_q;
  logic [2:0] sck_q;
  logic [1:0] sdi_q;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 2'b11;
      sck_q <= 3'b000;
      sdi_q <= 2'b00;
    end else begin
      cs_q  <= {cs_q[0], cs_n};
      sck_q <= {sck_q[1:0], sclk};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  assign cs_act    = ~cs_q[1] & rst_n_int;
  assign sclk_rise = sck_q[1] & ~sck_q[2];
  assign sclk_fall = ~sck_q[1] & sck_q[2];
  assign sdi_s     = sdi_q[1];

endmodule

// File: rtl/cvcmd_decode.sv
module cvcmd_decode
  import cvcmd_pkg::*;
(
  input  logic [CMD_W-1:0] byte_i,
  output cmd_dec_t         dec_o
);

  logic [2:0] sel;
  logic       valid;
  logic       single;

  assign sel    = byte_i[CB_SEL_HI:CB_SEL_LO];
  assign valid  = byte_i[CB_VALID];
  assign single = byte_i[CB_SINGLE];

  always_comb begin
    dec_o          = '0;
    dec_o.start    = (byte_i == CMD_CONVERT);
    dec_o.access   = valid & ~single & (sel <= SEL_ALL);
    dec_o.reserved = valid & ~single & (sel > SEL_ALL);
    dec_o.rd       = byte_i[CB_READ];
    dec_o.multi    = (sel == SEL_ALL);
    dec_o.ro       = (sel == SEL_DATA);
    dec_o.idx      = sel[1:0];
    dec_o.ps       = byte_i[CB_PS];
  end

endmodule

// File: rtl/cvcmd_regfile.sv
module cvcmd_regfile #(
  parameter int WORD_W   = 24,
  parameter int RES_W    = 20,
  parameter int FLAG_W   = 2,
  parameter int N_SETUP  = 3,
  parameter int CFG_IDX  = 2,
  parameter int DONE_BIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_idx_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  input  logic                      clr_done_i,
  input  logic                      conv_done_i,
  input  logic [RES_W-1:0]          conv_res_i,
  input  logic [FLAG_W-1:0]         conv_flags_i,
  output logic [N_SETUP*WORD_W-1:0] setup_o,
  output logic [WORD_W-1:0]         data_o
);

  localparam int PAD_W = WORD_W - RES_W - FLAG_W;

  logic              done_q, done_d;
  logic [WORD_W-1:0] data_q, data_d;

  for (genvar i = 0; i < N_SETUP; i++) begin : g_setup
    logic              en;
    logic [WORD_W-1:0] store_q;
    assign en = wr_en_i && (wr_idx_i == 2'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  store_q <= '0;
      else if (en) store_q <= wr_data_i;
    end
    if (i == CFG_IDX) begin : g_cfg
      always_comb begin
        setup_o[i*WORD_W +: WORD_W]           = store_q;
        setup_o[i*WORD_W + DONE_BIT]          = done_q;
      end
    end else begin : g_plain
      assign setup_o[i*WORD_W +: WORD_W] = store_q;
    end
  end

  always_comb begin
    done_d = done_q;
    if (clr_done_i)  done_d = 1'b0;
    if (conv_done_i) done_d = 1'b1;
    data_d = data_q;
    if (conv_done_i) data_d = {conv_res_i, {PAD_W{1'b0}}, conv_flags_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= done_d;
      if (conv_done_i) data_q <= data_d;
    end
  end

  assign data_o = data_q;

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i |=> done_q); // R9
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done_i && !conv_done_i) |=> !done_q); // R10
  AST_DATA_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_i |=> $stable(data_q)); // R6

endmodule

// File: rtl/cvcmd_port.sv
module cvcmd_port
  import cvcmd_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int RES_W    = 20,
  parameter int FLAG_W   = 2,
  parameter int DONE_BIT = 3,
  parameter int PSS_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic [RES_W-1:0]  conv_res_i,
  input  logic [FLAG_W-1:0] conv_flags_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic [WORD_W-1:0] ofs_o,
  output logic [WORD_W-1:0] gain_o,
  output logic [WORD_W-1:0] cfg_o,
  output logic              pwr_save_o,
  output logic              pwr_standby_o
);

  localparam int N_SETUP = 3;
  localparam int ALL_W   = N_SETUP * WORD_W;
  localparam int CNT_W   = $clog2(ALL_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ALL_LAST  = CNT_W'(ALL_W - 1);
  localparam logic [1:0]       LAST_IDX  = 2'(N_SETUP - 1);

  logic rst_n_int, cs_act, sclk_rise, sclk_fall, sdi_s;

  cvcmd_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .rst_n_int (rst_n_int),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_s     (sdi_s)
  );

  sif_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rlast_q, rlast_d;
  logic [WORD_W-1:0] sin_q, sin_d;
  logic [ALL_W-1:0]  sout_q, sout_d;
  logic              sdo_q, sdo_d;
  logic [1:0]        widx_q, widx_d, idx_q, idx_d;
  logic              multi_q, multi_d, ro_q, ro_d;
  logic              start_q, start_d, ps_q, ps_d;

  logic              wr_en, clr_done;
  logic [1:0]        wr_idx;
  logic [WORD_W-1:0] wr_data;
  logic [CMD_W-1:0]  cmd_byte;
  cmd_dec_t          dec;

  logic [ALL_W-1:0]  setup;
  logic [WORD_W-1:0] data_word, sel_word;
  logic [ALL_W-1:0]  all_word;
  logic              cmd_end;

  assign cmd_byte = {sin_q[CMD_W-2:0], sdi_s};
  assign wr_data  = {sin_q[WORD_W-2:0], sdi_s};

  cvcmd_decode u_dec (
    .byte_i (cmd_byte),
    .dec_o  (dec)
  );

  cvcmd_regfile #(
    .WORD_W   (WORD_W),
    .RES_W    (RES_W),
    .FLAG_W   (FLAG_W),
    .N_SETUP  (N_SETUP),
    .CFG_IDX  (2),
    .DONE_BIT (DONE_BIT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (wr_data),
    .clr_done_i   (clr_done),
    .conv_done_i  (conv_done_i),
    .conv_res_i   (conv_res_i),
    .conv_flags_i (conv_flags_i),
    .setup_o      (setup),
    .data_o       (data_word)
  );

  assign ofs_o  = setup[0*WORD_W +: WORD_W];
  assign gain_o = setup[1*WORD_W +: WORD_W];
  assign cfg_o  = setup[2*WORD_W +: WORD_W];

  // burst order: offset first on the wire
  assign all_word = {ofs_o, gain_o, cfg_o};

  always_comb begin
    unique case (dec.idx)
      2'd0:    sel_word = ofs_o;
      2'd1:    sel_word = gain_o;
      2'd2:    sel_word = cfg_o;
      default: sel_word = data_word;
    endcase
  end

  assign cmd_end = cs_act && sclk_rise && (st_q == ST_CMD) && (cnt_q == CMD_LAST);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rlast_d  = rlast_q;
    sin_d    = sin_q;
    sout_d   = sout_q;
    sdo_d    = sdo_q;
    widx_d   = widx_q;
    idx_d    = idx_q;
    multi_d  = multi_q;
    ro_d     = ro_q;
    ps_d     = ps_q;
    start_d  = 1'b0;
    wr_en    = 1'b0;
    wr_idx   = idx_q;
    clr_done = 1'b0;
    if (!cs_act) begin
      st_d   = ST_CMD;
      cnt_d  = '0;
      widx_d = '0;
      sdo_d  = 1'b0;
    end else if (sclk_rise) begin
      sin_d = wr_data;
      cnt_d = cnt_q + 1'b1;
      unique case (st_q)
        ST_CMD: begin
          if (cnt_q == CMD_LAST) begin
            cnt_d = '0;
            if (dec.start) begin
              start_d = 1'b1;
              ps_d    = dec.ps;
            end else if (dec.access) begin
              ps_d    = dec.ps;
              multi_d = dec.multi;
              ro_d    = dec.ro;
              idx_d   = dec.idx;
              widx_d  = '0;
              if (dec.rd) begin
                st_d     = ST_RD;
                rlast_d  = dec.multi ? ALL_LAST : WORD_LAST;
                sout_d   = dec.multi ? all_word
                                     : {sel_word, {(ALL_W-WORD_W){1'b0}}};
                clr_done = dec.ro & ~dec.multi;
              end else begin
                st_d = ST_WR;
              end
            end
          end
        end
        ST_WR: begin
          if (cnt_q == WORD_LAST) begin
            cnt_d  = '0;
            wr_en  = ~ro_q | multi_q;
            wr_idx = multi_q ? widx_q : idx_q;
            if (multi_q && (widx_q != LAST_IDX)) begin
              widx_d = widx_q + 1'b1;
            end else begin
              st_d   = ST_CMD;
              widx_d = '0;
            end
          end
        end
        ST_RD: begin
          if (cnt_q == rlast_q) begin
            cnt_d = '0;
            st_d  = ST_CMD;
          end
        end
        default: st_d = ST_CMD;
      endcase
    end else if (sclk_fall) begin
      if (st_q == ST_RD) begin
        sdo_d  = sout_q[ALL_W-1];
        sout_d = {sout_q[ALL_W-2:0], 1'b0};
      end else begin
        sdo_d = 1'b0;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q    <= ST_CMD;
      cnt_q   <= '0;
      rlast_q <= '0;
      sin_q   <= '0;
      sout_q  <= '0;
      sdo_q   <= 1'b0;
      widx_q  <= '0;
      idx_q   <= '0;
      multi_q <= 1'b0;
      ro_q    <= 1'b0;
      ps_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rlast_q <= rlast_d;
      sin_q   <= sin_d;
      sout_q  <= sout_d;
      sdo_q   <= sdo_d;
      widx_q  <= widx_d;
      idx_q   <= idx_d;
      multi_q <= multi_d;
      ro_q    <= ro_d;
      ps_q    <= ps_d;
      start_q <= start_d;
    end
  end

  assign sdo           = sdo_q;
  assign conv_start_o  = start_q;
  assign pwr_save_o    = ps_q;
  assign pwr_standby_o = ps_q & ~cfg_o[PSS_BIT];

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    conv_start_o |=> !conv_start_o); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cs_act |=> (st_q == ST_CMD && cnt_q == '0)); // R12
  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_end && dec.reserved) |=> ($stable(pwr_save_o) && st_q == ST_CMD)); // R7
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sclk_fall && cs_act) |=> $stable(sdo)); // R4

endmodule

// File: tb/cvcmd_port_tb.sv
module cvcmd_port_tb_top;

  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int SEED  = 32'h5EED_0427;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, sdi;
  logic        sdo;
  logic [19:0] conv_res_i;
  logic [1:0]  conv_flags_i;
  logic        conv_done_i;
  logic        conv_start_o;
  logic [23:0] ofs_o, gain_o, cfg_o;
  logic        pwr_save_o, pwr_standby_o;

  always #(CLK_P/2) clk = ~clk;

  cvcmd_port dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .sdi           (sdi),
    .sdo           (sdo),
    .conv_res_i    (conv_res_i),
    .conv_flags_i  (conv_flags_i),
    .conv_done_i   (conv_done_i),
    .conv_start_o  (conv_start_o),
    .ofs_o         (ofs_o),
    .gain_o        (gain_o),
    .cfg_o         (cfg_o),
    .pwr_save_o    (pwr_save_o),
    .pwr_standby_o (pwr_standby_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_start = 0;
  bit finished = 0;

  always @(posedge clk) if (rst_n && conv_start_o) n_start++;

  // bench model
  logic [23:0] m_reg [3];
  logic        m_done;
  logic        m_ps;
  logic [23:0] m_data;

  function automatic logic [7:0] cmd(input logic [2:0] sel, input logic rd, input logic ps);
    return {1'b1, 1'b0, sel, rd, 1'b0, ps};
  endfunction

  function automatic logic [23:0] exp_reg(input int idx);
    logic [23:0] v;
    v = m_reg[idx];
    if (idx == 2) v[3] = m_done;
    return v;
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [79:0] tx, input int n, output logic [79:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[78:0], sdo};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [79:0] tx, input int n, output logic [79:0] rx);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    shift_bits(tx, n, rx);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic ps, input logic [23:0] d);
    logic [79:0] rx;
    frame({48'd0, cmd(sel, 1'b0, ps), d}, 32, rx);
    m_ps = ps;
    if (sel <= 3'd2) m_reg[sel] = d;
  endtask

  task automatic rd_reg(input logic [2:0] sel, input logic ps, output logic [23:0] d);
    logic [79:0] rx;
    frame({48'd0, cmd(sel, 1'b1, ps), 24'd0}, 32, rx);
    m_ps = ps;
    d = rx[23:0];
    if (sel == 3'b011) m_done = 1'b0;
  endtask

  task automatic complete(input logic [19:0] res, input logic [1:0] fl);
    @(negedge clk);
    conv_res_i = res; conv_flags_i = fl; conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    m_done = 1'b1;
    m_data = {res, 2'b00, fl};
    repeat (2) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [23:0] d;
    logic [79:0] rx;
    int s0;
    d = $urandom(SEED);
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    conv_res_i = '0; conv_flags_i = '0; conv_done_i = 1'b0;
    for (int i = 0; i < 3; i++) m_reg[i] = '0;
    m_done = 1'b0; m_ps = 1'b0; m_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 ofs", 72'(ofs_o), 72'd0);
    chk("R1 gain/cfg", 72'({gain_o, cfg_o}), 72'd0);
    chk("R1 sdo/pwr/start", 72'({sdo, pwr_save_o, pwr_standby_o, conv_start_o}), 72'd0);

    // R3/R4 directed single-register writes and reads
    wr_reg(3'b000, 1'b0, 24'hA5C3F0);
    wr_reg(3'b001, 1'b0, 24'h800001);
    wr_reg(3'b010, 1'b0, 24'h7FFFF7);
    chk("R3 ofs parallel", 72'(ofs_o), 72'(exp_reg(0)));
    chk("R3 gain parallel", 72'(gain_o), 72'(exp_reg(1)));
    chk("R3 cfg parallel", 72'(cfg_o), 72'(exp_reg(2)));
    rd_reg(3'b000, 1'b0, d); chk("R4 ofs serial", 72'(d), 72'(exp_reg(0)));
    rd_reg(3'b001, 1'b0, d); chk("R4 gain serial", 72'(d), 72'(exp_reg(1)));

    // R5 burst write and read
    frame({cmd(3'b100, 1'b0, 1'b0), 24'h123456, 24'hFEDCBA, 24'h0F0F00}, 80, rx);
    m_reg[0] = 24'h123456; m_reg[1] = 24'hFEDCBA; m_reg[2] = 24'h0F0F00;
    chk("R5 burst write", 72'({ofs_o, gain_o, cfg_o}), {exp_reg(0), exp_reg(1), exp_reg(2)});
    frame({cmd(3'b100, 1'b1, 1'b0), 72'd0}, 80, rx);
    chk("R5 burst read", rx[71:0], {exp_reg(0), exp_reg(1), exp_reg(2)});

    // R2 invalid byte then a real command in one frame
    frame({8'h00, 8'h00, cmd(3'b000, 1'b0, 1'b0), 24'h00BEEF}, 40, rx);
    m_reg[0] = 24'h00BEEF;
    chk("R2 recover after invalid", 72'(ofs_o), 72'(exp_reg(0)));
    frame({72'd0, 8'h41}, 8, rx);
    chk("R2 invalid ignored", 72'({ofs_o, gain_o, cfg_o, pwr_save_o}), 72'({exp_reg(0), exp_reg(1), exp_reg(2), m_ps}));

    // R9 completion, R10 done flag
    complete(20'hABCDE, 2'b10);
    rd_reg(3'b010, 1'b0, d); chk("R9 done set", 72'(d[3]), 72'd1);
    // R6 write to conversion word ignored
    wr_reg(3'b011, 1'b0, 24'h55AA55);
    chk("R6 setup unchanged", 72'({ofs_o, gain_o, cfg_o}), {exp_reg(0), exp_reg(1), exp_reg(2)});
    rd_reg(3'b011, 1'b0, d); chk("R9 R6 data word", 72'(d), 72'(m_data));
    chk("R10 done cleared", 72'(cfg_o[3]), 72'd0);
    wr_reg(3'b010, 1'b0, 24'h00000F);
    chk("R10 done not writable", 72'(cfg_o), 72'(exp_reg(2)));

    // R7 reserved codes
    for (int c = 5; c < 8; c++) begin
      frame({72'd0, cmd(3'(c), 1'b0, 1'b1)}, 8, rx);
      chk("R7 reserved no effect", 72'({ofs_o, gain_o, cfg_o, pwr_save_o}),
          72'({exp_reg(0), exp_reg(1), exp_reg(2), m_ps}));
    end

    // R8 conversion start
    s0 = n_start;
    frame({72'd0, 8'hC0}, 8, rx);
    chk("R8 one start", 72'(n_start - s0), 72'd1);
    frame({72'd0, 8'hC8}, 8, rx);
    frame({72'd0, 8'hC1}, 8, rx);
    chk("R8 malformed ignored", 72'(n_start - s0), 72'd1);
    chk("R8 malformed state", 72'({ofs_o, gain_o, cfg_o, pwr_save_o}),
        72'({exp_reg(0), exp_reg(1), exp_reg(2), 1'b0}));

    // R11 power save and mode
    wr_reg(3'b010, 1'b1, 24'h000000);
    chk("R11 standby", 72'({pwr_save_o, pwr_standby_o}), 72'b11);
    wr_reg(3'b010, 1'b1, 24'h000010);
    chk("R11 other mode", 72'({pwr_save_o, pwr_standby_o}), 72'b10);
    s0 = n_start;
    frame({72'd0, 8'hC0}, 8, rx);
    chk("R11 R8 convert sets run", 72'({pwr_save_o, 32'(n_start - s0)}), 72'd1);
    m_ps = 1'b0;

    // R12 abort mid-word
    frame({48'd0, cmd(3'b001, 1'b0, 1'b0), 24'hC0FFEE}, 20, rx);
    chk("R12 partial dropped", 72'(gain_o), 72'(exp_reg(1)));
    rd_reg(3'b001, 1'b0, d);
    chk("R12 next frame ok", 72'(d), 72'(exp_reg(1)));

    // random register traffic
    for (int it = 0; it < 30; it++) begin
      logic [2:0]  sel;
      logic [23:0] v;
      logic        ps;
      sel = 3'($urandom_range(0, 2));
      v   = 24'($urandom);
      ps  = 1'($urandom);
      wr_reg(sel, ps, v);
      chk("R3 R11 random write", 72'({ofs_o, gain_o, cfg_o, pwr_save_o}),
          72'({exp_reg(0), exp_reg(1), exp_reg(2), m_ps}));
      rd_reg(sel, 1'b0, d);
      chk("R4 random read", 72'(d), 72'(exp_reg(int'(sel))));
    end

    finished = 1;
    report();
  end

endmodule